// File: doc/BRIEF.md
# Processor Power State Controller

This block decides when a multi-threaded core may drop into a low-power halt and brings it back. Each logical thread reports its own halt flag. The controller leaves its normal state only once every thread is halted. A single configuration bit chooses the kind of halt. The plain halt keeps the operating point. The enhanced halt lowers the core clock ratio and then the voltage ID, and it raises them again in the reverse order on the way out.

Every operating-point step is a request/done handshake with an external ratio stub or voltage stub. Before entry, the controller captures the operating point that was in force, and exit restores exactly those values. Five wake sources end a halt. A wake that arrives during enhanced entry is held until entry finishes and then triggers the exit sequence.

From plain halt, a stop-clock request moves the block to a stop-grant state. In that state it emits one acknowledge pulse per thread, then goes back to halt when the request drops.

Top module: `pwr_state_ctrl`

## Requirements
- R1: NORMAL is left only when every bit of `thread_halt` is 1 and no wake bit is set in that cycle. A partial halt keeps the state at NORMAL.
- R2: With `ehalt_en` = 0, leaving NORMAL goes to HALT, and `ratio_sel` and `vid_sel` stay unchanged. `ehalt_en` is sampled only on the transition out of NORMAL.
- R3: Enhanced entry first drives `ratio_sel` to LOW_RATIO with `ratio_req` high. Only after `ratio_done` does it drive `vid_sel` to LOW_VID with `vid_req` high. After `vid_done` the state is EHALT.
- R4: Enhanced exit first restores `vid_sel` with `vid_req` high. After `vid_done` it restores `ratio_sel` with `ratio_req` high. After `ratio_done` the state is NORMAL.
- R5: Any set bit of `wake_src` returns HALT to NORMAL and starts the exit from EHALT. The bit map is 0 = SMI, 1 = INIT, 2 = BINIT, 3 = NMI/INTR, 4 = interrupt delivered over the bus.
- R6: An active-low `rst_n` asynchronously forces NORMAL, `ratio_sel` = RST_RATIO, `vid_sel` = RST_VID, both requests low and no acknowledge.
- R7: In HALT, `stpclk_req` = 1 moves the state to STOPGRANT. Once the request is 0, the state returns to HALT and never goes directly to NORMAL. Wake bits are ignored in STOPGRANT.
- R8: In STOPGRANT, `sg_ack` bit i pulses for exactly one cycle, in the (i+1)-th STOPGRANT cycle. STOPGRANT is left no earlier than the cycle after the last pulse.
- R9: `snoop_ok` is 1 in NORMAL, HALT, EHALT and STOPGRANT, and 0 during the EHALT_ENTER and EHALT_EXIT steps.
- R10: A wake that occurs during EHALT_ENTER is held. When `vid_done` completes entry, the state goes straight to EHALT_EXIT.
- R11: In NORMAL, `ratio_sel`/`vid_sel` follow `nom_ratio`/`nom_vid` one cycle later. Exit restores the values captured at entry, even if the nominal inputs changed during the halt.
- R12: A `ratio_done` or `vid_done` strobe that does not belong to the current step has no effect.
- R13: `pstate` encodes NORMAL = 0, HALT = 1, EHALT_ENTER = 2, EHALT = 3, EHALT_EXIT = 4, STOPGRANT = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_halt | input | NUM_THREADS | Per-thread halt flag |
| ehalt_en | input | 1 | Selects enhanced halt |
| wake_src | input | 5 | Wake sources (map in R5) |
| stpclk_req | input | 1 | Stop-clock request |
| nom_ratio | input | RATIO_W | Nominal core ratio |
| nom_vid | input | VID_W | Nominal voltage ID |
| ratio_done | input | 1 | Ratio stub step complete |
| vid_done | input | 1 | Voltage stub step complete |
| ratio_sel | output | RATIO_W | Selected core ratio |
| ratio_req | output | 1 | Ratio step pending |
| vid_sel | output | VID_W | Selected voltage ID |
| vid_req | output | 1 | Voltage step pending |
| sg_ack | output | NUM_THREADS | Stop-grant acknowledge pulses |
| snoop_ok | output | 1 | Snoops may be served |
| pstate | output | 3 | Controller state (R13) |

## Verification
All outputs come from registers. `pstate`, `ratio_sel`, `vid_sel`, the requests and `snoop_ok` therefore settle one clock edge after the input that causes them, and the acknowledge for thread i follows i edges after the edge that enters STOPGRANT. Reset acts without waiting for a clock. The bench applies each stimulus on a falling edge and compares every output on the next falling edge, which makes each table row exactly one edge of latency. For reset, it samples one nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  localparam int WAKE_W = 5;

  typedef enum logic [2:0] {
    PS_NORMAL   = 3'd0,
    PS_HALT     = 3'd1,
    PS_EH_ENTER = 3'd2,
    PS_EH       = 3'd3,
    PS_EH_EXIT  = 3'd4,
    PS_STOPGNT  = 3'd5
  } pstate_e;

  // ratio stub is busy: first step of entry, second step of exit
  function automatic logic f_ratio_step(pstate_e st, logic ph);
    return (st == PS_EH_ENTER && !ph) || (st == PS_EH_EXIT && ph);
  endfunction

  // voltage stub is busy: second step of entry, first step of exit
  function automatic logic f_vid_step(pstate_e st, logic ph);
    return (st == PS_EH_ENTER && ph) || (st == PS_EH_EXIT && !ph);
  endfunction

  // the done strobe that counts for the step in progress
  function automatic logic f_step_done(pstate_e st, logic ph, logic rdone, logic vdone);
    return (f_ratio_step(st, ph) && rdone) || (f_vid_step(st, ph) && vdone);
  endfunction

  function automatic logic f_transit(pstate_e st);
    return (st == PS_EH_ENTER) || (st == PS_EH_EXIT);
  endfunction

endpackage

// File: rtl/pwr_wake_merge.sv
module pwr_wake_merge
  import pwr_state_pkg::*;
#(
  parameter int SRC_W = WAKE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] wake_src,
  input  pstate_e          st,
  input  logic             leave_entry,
  output logic             wake_any,
  output logic             wake_pend
);

  logic pend_q;

  assign wake_any  = |wake_src;
  assign wake_pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (st == PS_EH_ENTER && !leave_entry) begin
      pend_q <= pend_q | wake_any;
    end else begin
      pend_q <= 1'b0;
    end
  end

  // R10: a held wake only exists while entry is under way
  p_pend_in_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend |-> st == PS_EH_ENTER);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_state_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    all_halt,
  input  logic    ehalt_en,
  input  logic    wake_any,
  input  logic    wake_pend,
  input  logic    stpclk_req,
  input  logic    sg_fin,
  input  logic    ratio_done,
  input  logic    vid_done,
  output pstate_e st_o,
  output logic    leave_entry,
  output logic    ev_cap,
  output logic    ev_vid_low,
  output logic    ev_vid_rest,
  output logic    ev_ratio_rest,
  output logic    track_en,
  output logic    ratio_req,
  output logic    vid_req,
  output logic    snoop_ok
);

  pstate_e st_q, st_d;
  logic    ph_q, ph_d;
  logic    step_done;

  assign step_done = f_step_done(st_q, ph_q, ratio_done, vid_done);

  always_comb begin
    st_d          = st_q;
    ph_d          = ph_q;
    ev_cap        = 1'b0;
    ev_vid_low    = 1'b0;
    ev_vid_rest   = 1'b0;
    ev_ratio_rest = 1'b0;
    unique case (st_q)
      PS_NORMAL: begin
        if (all_halt && !wake_any) begin
          if (ehalt_en) begin
            st_d   = PS_EH_ENTER;
            ph_d   = 1'b0;
            ev_cap = 1'b1;
          end else begin
            st_d = PS_HALT;
          end
        end
      end
      PS_HALT: begin
        if (wake_any)        st_d = PS_NORMAL;
        else if (stpclk_req) st_d = PS_STOPGNT;
      end
      PS_STOPGNT: begin
        if (!stpclk_req && sg_fin) st_d = PS_HALT;
      end
      PS_EH_ENTER: begin
        if (step_done) begin
          if (!ph_q) begin
            ph_d       = 1'b1;
            ev_vid_low = 1'b1;
          end else if (wake_pend || wake_any) begin
            st_d        = PS_EH_EXIT;
            ph_d        = 1'b0;
            ev_vid_rest = 1'b1;
          end else begin
            st_d = PS_EH;
          end
        end
      end
      PS_EH: begin
        if (wake_any) begin
          st_d        = PS_EH_EXIT;
          ph_d        = 1'b0;
          ev_vid_rest = 1'b1;
        end
      end
      PS_EH_EXIT: begin
        if (step_done) begin
          if (!ph_q) begin
            ph_d          = 1'b1;
            ev_ratio_rest = 1'b1;
          end else begin
            st_d = PS_NORMAL;
          end
        end
      end
      default: st_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_NORMAL;
      ph_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign st_o        = st_q;
  assign leave_entry = (st_q == PS_EH_ENTER) && (st_d != PS_EH_ENTER);
  assign track_en    = (st_q == PS_NORMAL);
  assign ratio_req   = f_ratio_step(st_q, ph_q);
  assign vid_req     = f_vid_step(st_q, ph_q);
  assign snoop_ok    = !f_transit(st_q);

  // R1: a partial halt keeps the core running
  p_partial_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_NORMAL && !all_halt) |=> st_q == PS_NORMAL);

  // R5: a wake in plain halt returns to normal
  p_wake_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HALT && wake_any) |=> st_q == PS_NORMAL);

  // R7: stop-grant returns to halt, never to normal
  p_sg_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOPGNT && !stpclk_req && sg_fin) |=> st_q == PS_HALT);

  p_sg_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOPGNT && stpclk_req) |=> st_q == PS_STOPGNT);

  // R9: snoops stay allowed in both halt flavours
  p_snoop_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HALT || st_q == PS_EH) |-> snoop_ok);

  // R10: held wake sends entry completion straight into exit
  p_pend_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_EH_ENTER && vid_req && vid_done && wake_pend) |=> st_q == PS_EH_EXIT);

  // R12: only one stub is ever asked at a time
  p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_req && vid_req));

endmodule

// File: rtl/pwr_op_point.sv
module pwr_op_point #(
  parameter int              RATIO_W   = 5,
  parameter int              VID_W     = 6,
  parameter logic [RATIO_W-1:0] LOW_RATIO = 5'd6,
  parameter logic [VID_W-1:0]   LOW_VID   = 6'd20,
  parameter logic [RATIO_W-1:0] RST_RATIO = 5'd12,
  parameter logic [VID_W-1:0]   RST_VID   = 6'd30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] nom_ratio,
  input  logic [VID_W-1:0]   nom_vid,
  input  logic               ev_cap,
  input  logic               ev_vid_low,
  input  logic               ev_vid_rest,
  input  logic               ev_ratio_rest,
  input  logic               track_en,
  output logic [RATIO_W-1:0] ratio_sel,
  output logic [VID_W-1:0]   vid_sel
);

  logic [RATIO_W-1:0] ratio_q, ratio_save_q;
  logic [VID_W-1:0]   vid_q, vid_save_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q      <= RST_RATIO;
      vid_q        <= RST_VID;
      ratio_save_q <= RST_RATIO;
      vid_save_q   <= RST_VID;
    end else if (ev_cap) begin
      ratio_save_q <= ratio_q;
      vid_save_q   <= vid_q;
      ratio_q      <= LOW_RATIO;
    end else if (ev_vid_low) begin
      vid_q <= LOW_VID;
    end else if (ev_vid_rest) begin
      vid_q <= vid_save_q;
    end else if (ev_ratio_rest) begin
      ratio_q <= ratio_save_q;
    end else if (track_en) begin
      ratio_q <= nom_ratio;
      vid_q   <= nom_vid;
    end
  end

  assign ratio_sel = ratio_q;
  assign vid_sel   = vid_q;

  // R3: the voltage drops only once the ratio is already low
  p_vid_after_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vid_low |-> ratio_q == LOW_RATIO);

  // R4: the ratio comes back only once the voltage is restored
  p_ratio_after_vid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ratio_rest |-> vid_q == vid_save_q);

  // R11: captured values are not disturbed between capture and restore
  p_save_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cap |=> $stable(ratio_save_q) && $stable(vid_save_q));

endmodule

// File: rtl/pwr_sg_ack.sv
module pwr_sg_ack
  import pwr_state_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pstate_e                st,
  output logic [NUM_THREADS-1:0] ack,
  output logic                   sg_fin
);

  localparam int CNT_W = $clog2(NUM_THREADS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NUM_THREADS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_THREADS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             in_sg;

  assign in_sg = (st == PS_STOPGNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!in_sg)          cnt_q <= '0;
    else if (cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_ack
    assign ack[i] = in_sg && (cnt_q == CNT_W'(i));
  end

  assign sg_fin = in_sg && (cnt_q >= CNT_LAST);

  // R8: at most one thread acknowledged per cycle
  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  p_ack_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |=> ack != $past(ack));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int                 NUM_THREADS = 2,
  parameter int                 RATIO_W     = 5,
  parameter int                 VID_W       = 6,
  parameter logic [RATIO_W-1:0] LOW_RATIO   = 5'd6,
  parameter logic [VID_W-1:0]   LOW_VID     = 6'd20,
  parameter logic [RATIO_W-1:0] RST_RATIO   = 5'd12,
  parameter logic [VID_W-1:0]   RST_VID     = 6'd30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thread_halt,
  input  logic                   ehalt_en,
  input  logic [WAKE_W-1:0]      wake_src,
  input  logic                   stpclk_req,
  input  logic [RATIO_W-1:0]     nom_ratio,
  input  logic [VID_W-1:0]       nom_vid,
  input  logic                   ratio_done,
  input  logic                   vid_done,
  output logic [RATIO_W-1:0]     ratio_sel,
  output logic                   ratio_req,
  output logic [VID_W-1:0]       vid_sel,
  output logic                   vid_req,
  output logic [NUM_THREADS-1:0] sg_ack,
  output logic                   snoop_ok,
  output logic [2:0]             pstate
);

  pstate_e st;
  logic    all_halt, wake_any, wake_pend, leave_entry, sg_fin;
  logic    ev_cap, ev_vid_low, ev_vid_rest, ev_ratio_rest, track_en;

  assign all_halt = &thread_halt;

  pwr_wake_merge #(.SRC_W(WAKE_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .wake_src(wake_src), .st(st),
    .leave_entry(leave_entry), .wake_any(wake_any), .wake_pend(wake_pend)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .all_halt(all_halt), .ehalt_en(ehalt_en),
    .wake_any(wake_any), .wake_pend(wake_pend), .stpclk_req(stpclk_req),
    .sg_fin(sg_fin), .ratio_done(ratio_done), .vid_done(vid_done),
    .st_o(st), .leave_entry(leave_entry), .ev_cap(ev_cap),
    .ev_vid_low(ev_vid_low), .ev_vid_rest(ev_vid_rest),
    .ev_ratio_rest(ev_ratio_rest), .track_en(track_en),
    .ratio_req(ratio_req), .vid_req(vid_req), .snoop_ok(snoop_ok)
  );

  pwr_op_point #(
    .RATIO_W(RATIO_W), .VID_W(VID_W), .LOW_RATIO(LOW_RATIO),
    .LOW_VID(LOW_VID), .RST_RATIO(RST_RATIO), .RST_VID(RST_VID)
  ) u_op (
    .clk(clk), .rst_n(rst_n), .nom_ratio(nom_ratio), .nom_vid(nom_vid),
    .ev_cap(ev_cap), .ev_vid_low(ev_vid_low), .ev_vid_rest(ev_vid_rest),
    .ev_ratio_rest(ev_ratio_rest), .track_en(track_en),
    .ratio_sel(ratio_sel), .vid_sel(vid_sel)
  );

  pwr_sg_ack #(.NUM_THREADS(NUM_THREADS)) u_sg (
    .clk(clk), .rst_n(rst_n), .st(st), .ack(sg_ack), .sg_fin(sg_fin)
  );

  assign pstate = st;

  // R2: plain halt never touches the operating point
  p_plain_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd1 && $past(pstate) == 3'd1) |-> $stable(ratio_sel) && $stable(vid_sel));

  // R3: while the voltage is being lowered the ratio is already low
  p_entry_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd2 && vid_req) |-> ratio_sel == LOW_RATIO);

  // R4: while the voltage is being restored the ratio stays low
  p_exit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd4 && vid_req) |-> ratio_sel == LOW_RATIO);

  // R8: acknowledges appear only in stop-grant
  p_ack_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|sg_ack) |-> pstate == 3'd5);

endmodule

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] thread_halt = '0;
  logic       ehalt_en = 1'b0;
  logic [4:0] wake_src = '0;
  logic       stpclk_req = 1'b0;
  logic [4:0] nom_ratio = 5'd18;
  logic [5:0] nom_vid = 6'd40;
  logic       ratio_done = 1'b0;
  logic       vid_done = 1'b0;
  logic [4:0] ratio_sel;
  logic       ratio_req;
  logic [5:0] vid_sel;
  logic       vid_req;
  logic [1:0] sg_ack;
  logic       snoop_ok;
  logic [2:0] pstate;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .thread_halt(thread_halt), .ehalt_en(ehalt_en),
    .wake_src(wake_src), .stpclk_req(stpclk_req), .nom_ratio(nom_ratio),
    .nom_vid(nom_vid), .ratio_done(ratio_done), .vid_done(vid_done),
    .ratio_sel(ratio_sel), .ratio_req(ratio_req), .vid_sel(vid_sel),
    .vid_req(vid_req), .sg_ack(sg_ack), .snoop_ok(snoop_ok), .pstate(pstate)
  );

  typedef struct packed {
    logic [1:0] halt; logic en; logic [4:0] wake; logic stp; logic rd; logic vd;
    logic [2:0] st; logic rr; logic vr; logic [1:0] ack; logic snp;
    logic [4:0] ratio; logic [5:0] vid;
  } row_t;

  localparam int NROWS = 34;
  // stimulus | expected state, ratio_req, vid_req, ack, snoop, ratio, vid
  localparam row_t TBL [NROWS] = '{
    '{2'b00,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R11 track
    '{2'b01,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R1 partial
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R2 plain
    '{2'b11,1'b0,5'h00,1'b1,1'b0,1'b0, 3'd5,1'b0,1'b0,2'b01,1'b1,5'd18,6'd40}, // R7
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b0,2'b10,1'b1,5'd18,6'd40}, // R8 hold
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R8 back
    '{2'b11,1'b0,5'h01,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R5 SMI
    '{2'b00,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R13
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R1
    '{2'b11,1'b0,5'h00,1'b1,1'b0,1'b0, 3'd5,1'b0,1'b0,2'b01,1'b1,5'd18,6'd40}, // R7
    '{2'b11,1'b0,5'h04,1'b1,1'b0,1'b0, 3'd5,1'b0,1'b0,2'b10,1'b1,5'd18,6'd40}, // R7 wake ignored
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R7 to HALT
    '{2'b11,1'b0,5'h08,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R5 NMI/INTR
    '{2'b00,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R1
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,2'b00,1'b0,5'd6, 6'd40}, // R3 ratio step
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,2'b00,1'b0,5'd6, 6'd40}, // R12 stray vid_done
    '{2'b11,1'b1,5'h00,1'b0,1'b1,1'b0, 3'd2,1'b0,1'b1,2'b00,1'b0,5'd6, 6'd20}, // R3 vid step
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b1, 3'd3,1'b0,1'b0,2'b00,1'b1,5'd6, 6'd20}, // R3 in EHALT
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b0,2'b00,1'b1,5'd6, 6'd20}, // R9
    '{2'b00,1'b1,5'h10,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,2'b00,1'b0,5'd6, 6'd40}, // R4 bus wake
    '{2'b00,1'b1,5'h00,1'b0,1'b1,1'b0, 3'd4,1'b0,1'b1,2'b00,1'b0,5'd6, 6'd40}, // R12 stray ratio_done
    '{2'b00,1'b1,5'h00,1'b0,1'b0,1'b1, 3'd4,1'b1,1'b0,2'b00,1'b0,5'd18,6'd40}, // R4 ratio restore
    '{2'b00,1'b1,5'h00,1'b0,1'b1,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R4 done
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,2'b00,1'b0,5'd6, 6'd40}, // R3
    '{2'b11,1'b1,5'h02,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,2'b00,1'b0,5'd6, 6'd40}, // R10 INIT held
    '{2'b11,1'b1,5'h00,1'b0,1'b1,1'b0, 3'd2,1'b0,1'b1,2'b00,1'b0,5'd6, 6'd20}, // R10
    '{2'b00,1'b1,5'h00,1'b0,1'b0,1'b1, 3'd4,1'b0,1'b1,2'b00,1'b0,5'd6, 6'd40}, // R10 to exit
    '{2'b00,1'b1,5'h00,1'b0,1'b0,1'b1, 3'd4,1'b1,1'b0,2'b00,1'b0,5'd18,6'd40}, // R4
    '{2'b00,1'b1,5'h00,1'b0,1'b1,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R4
    '{2'b11,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R2
    '{2'b11,1'b1,5'h00,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R2 late enable
    '{2'b00,1'b1,5'h04,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R5 BINIT
    '{2'b11,1'b0,5'h08,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}, // R1 wake blocks
    '{2'b00,1'b0,5'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,2'b00,1'b1,5'd18,6'd40}  // R1
  };

  localparam string TAG [NROWS] = '{
    "R11","R1","R2","R7","R8","R8","R5","R13","R1","R7","R7","R7","R5","R1",
    "R3","R12","R3","R3","R9","R4","R12","R4","R4","R3","R10","R10","R10",
    "R4","R4","R2","R2","R5","R1","R1"
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] h, input logic e, input logic [4:0] w,
                       input logic s, input logic r, input logic v);
    thread_halt = h; ehalt_en = e; wake_src = w; stpclk_req = s;
    ratio_done = r; vid_done = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R6 R13: reset state
    chk("R6", "state", int'(pstate), 0);
    chk("R6", "ratio", int'(ratio_sel), 12);
    chk("R6", "vid", int'(vid_sel), 30);
    chk("R6", "reqs", int'({ratio_req, vid_req}), 0);
    chk("R6", "ack", int'(sg_ack), 0);
    chk("R9", "snoop", int'(snoop_ok), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].halt, TBL[i].en, TBL[i].wake, TBL[i].stp, TBL[i].rd, TBL[i].vd);
      chk(TAG[i], $sformatf("row%0d state", i), int'(pstate), int'(TBL[i].st));
      chk(TAG[i], $sformatf("row%0d ratio_req", i), int'(ratio_req), int'(TBL[i].rr));
      chk(TAG[i], $sformatf("row%0d vid_req", i), int'(vid_req), int'(TBL[i].vr));
      chk(TAG[i], $sformatf("row%0d ack", i), int'(sg_ack), int'(TBL[i].ack));
      chk(TAG[i], $sformatf("row%0d snoop", i), int'(snoop_ok), int'(TBL[i].snp));
      chk(TAG[i], $sformatf("row%0d ratio", i), int'(ratio_sel), int'(TBL[i].ratio));
      chk(TAG[i], $sformatf("row%0d vid", i), int'(vid_sel), int'(TBL[i].vid));
    end

    // R11: nominal point changes while halted; exit restores the captured one
    drive(2'b11, 1'b1, 5'h00, 1'b0, 1'b0, 1'b0);
    drive(2'b11, 1'b1, 5'h00, 1'b0, 1'b1, 1'b0);
    drive(2'b11, 1'b1, 5'h00, 1'b0, 1'b0, 1'b1);
    chk("R11", "in EHALT", int'(pstate), 3);
    nom_ratio = 5'd25;
    nom_vid   = 6'd50;
    drive(2'b00, 1'b0, 5'h01, 1'b0, 1'b0, 1'b0);
    chk("R11", "vid restored", int'(vid_sel), 40);
    chk("R11", "ratio still low", int'(ratio_sel), 6);
    drive(2'b00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
    chk("R11", "ratio restored", int'(ratio_sel), 18);
    drive(2'b00, 1'b0, 5'h00, 1'b0, 1'b1, 1'b0);
    chk("R11", "back to NORMAL", int'(pstate), 0);
    chk("R11", "ratio before tracking", int'(ratio_sel), 18);
    drive(2'b00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0);
    chk("R11", "ratio tracks", int'(ratio_sel), 25);
    chk("R11", "vid tracks", int'(vid_sel), 50);

    // R6: asynchronous reset in the middle of enhanced entry
    drive(2'b11, 1'b1, 5'h00, 1'b0, 1'b0, 1'b0);
    chk("R6", "entry started", int'(pstate), 2);
    rst_n = 1'b0;
    #1;
    chk("R6", "async state", int'(pstate), 0);
    chk("R6", "async ratio", int'(ratio_sel), 12);
    chk("R6", "async vid", int'(vid_sel), 30);
    chk("R6", "async ratio_req", int'(ratio_req), 0);
    @(negedge clk);
    thread_halt = 2'b00;
    rst_n = 1'b1;
    drive(2'b00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0);
    chk("R6", "after release", int'(pstate), 0);
    chk("R11", "tracks after reset", int'(ratio_sel), 25);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule